// File: doc/BRIEF.md
# Layer 3/4 Packet Filter Matcher

This block judges a received IP frame against up to four independent filter sets and decides whether the frame is forwarded or dropped. Its input is a header descriptor that an upstream parser has already filled in. The descriptor carries the IP version, a TCP/UDP flag, a UDP indication, the source and destination IP addresses, and the source and destination ports. Each filter set holds a control word, one port word and four 32-bit address words.

A filter can test the IP source address, the IP destination address, the source port and the destination port. Each of these tests has its own enable and its own inverse option. The two address tests can also ignore a chosen number of low-order bits. All filters are evaluated in parallel. When more than one filter matches, the lowest-numbered one wins.

IP frames that are neither TCP nor UDP skip the filters. A global option can drop them instead. A dropped frame is either discarded outright or marked for partial delivery with an abort flag. The verdict is registered, so it appears one cycle after the descriptor strobe.

Top module: `l34_filter_match`

## Requirements
- R1: After reset, `dec_valid` is 0. `dec_valid` goes high exactly one clock after a cycle in which `hdr_valid` is high, and stays low otherwise.
- R2: A filter counts as active when at least one of these enable bits is set: control bit 0 (source IP), bit 2 (destination IP), bit 19 (source port) or bit 21 (destination port). An active filter matches only when every one of its enabled tests passes. An inactive filter never matches.
- R3: When several filters match, `dec_idx` reports the lowest-numbered one. In every case a match sets `dec_match` and `dec_forward`.
- R4: A TCP/UDP frame that matches no filter, while at least one filter is active, is dropped: `dec_forward`=0 and `dec_match`=0. `dec_abort` then equals `cfg_abort_mode`. `dec_abort` is 0 whenever the frame is forwarded.
- R5: When no filter is active, every TCP/UDP frame is forwarded with `dec_match`=0.
- R6: Control bit 1 inverts the source IP test, and bit 3 inverts the destination IP test. Bit 20 inverts the source port test, and bit 22 inverts the destination port test.
- R7: Control bits 11:5 give the number of low-order bits to ignore in the source IP comparison. Bits 18:12 do the same for the destination IP comparison.
- R8: In IPv4 mode (control bit 4 = 0), address word 1 holds the source address and address word 2 holds the destination address. Words 0 and 3 are ignored. The descriptor carries an IPv4 address in bits 31:0.
- R9: In IPv6 mode (control bit 4 = 1), the 128-bit address is the concatenation of words 0, 1, 2 and 3. The first received byte sits in bits 31:24 of word 0, which is bit 127:120 of the descriptor address. This address is compared with the source address if bit 0 is set, or with the destination address if bit 2 is set. If both bits are set, the filter never matches. An address test also fails when the frame's IP version differs from the filter's mode.
- R10: A frame with `hdr_l4`=0 never matches. It is forwarded when `cfg_drop_non_l4`=0 and dropped when `cfg_drop_non_l4`=1, with `dec_abort` following R4.
- R11: The port word holds the source port in bits 15:0 and the destination port in bits 31:16. Control bit 23 selects the protocol (0 = TCP, 1 = UDP). A port test fails when the frame's protocol differs from this selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ctrl | input | NF*32 | Control words, filter f at bits f*32 |
| cfg_l4 | input | NF*32 | Port words, filter f at bits f*32 |
| cfg_l3 | input | NF*128 | Address words, word r of filter f at bits f*128+r*32 |
| cfg_drop_non_l4 | input | 1 | Drop IP frames that are not TCP/UDP |
| cfg_abort_mode | input | 1 | 1: a dropped frame is delivered partially with an abort flag |
| hdr_valid | input | 1 | Descriptor strobe |
| hdr_ipv6 | input | 1 | Frame is IPv6 |
| hdr_l4 | input | 1 | Frame is TCP or UDP |
| hdr_udp | input | 1 | Frame is UDP (otherwise TCP) |
| hdr_src_ip | input | 128 | Source IP address |
| hdr_dst_ip | input | 128 | Destination IP address |
| hdr_sport | input | 16 | Source port |
| hdr_dport | input | 16 | Destination port |
| dec_valid | output | 1 | Verdict valid |
| dec_forward | output | 1 | Forward (1) or drop (0) |
| dec_match | output | 1 | A filter matched |
| dec_idx | output | IW | Index of the matching filter |
| dec_abort | output | 1 | Dropped frame delivered partially with abort |

## Verification
The matcher is driven with exact and near-miss source addresses, which separates perfect matching from a comparison that is too loose. Masked addresses that differ just below and just above the ignored bit range show where the mask boundary falls. Inverse settings, overlapping filters, swapped TCP/UDP protocols and swapped port positions reveal inversion errors, priority errors and wrongly placed fields. IPv6 addresses, IPv4 values placed in the unused words, and frames that are not TCP/UDP with both drop options show whether the address words are laid out correctly and whether the bypass path works.

// File: rtl/l34_filter_match.sv
module l34_filter_match #(
  parameter int NF = 4,
  parameter int AW = 128,
  parameter int PW = 16,
  localparam int IW = (NF > 1) ? $clog2(NF) : 1,
  localparam int WW = 32,
  localparam int V4 = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NF*WW-1:0]  cfg_ctrl,
  input  logic [NF*WW-1:0]  cfg_l4,
  input  logic [NF*AW-1:0]  cfg_l3,
  input  logic              cfg_drop_non_l4,
  input  logic              cfg_abort_mode,
  input  logic              hdr_valid,
  input  logic              hdr_ipv6,
  input  logic              hdr_l4,
  input  logic              hdr_udp,
  input  logic [AW-1:0]     hdr_src_ip,
  input  logic [AW-1:0]     hdr_dst_ip,
  input  logic [PW-1:0]     hdr_sport,
  input  logic [PW-1:0]     hdr_dport,
  output logic              dec_valid,
  output logic              dec_forward,
  output logic              dec_match,
  output logic [IW-1:0]     dec_idx,
  output logic              dec_abort
);

  logic [NF-1:0] active, hit;

  wire [AW-1:0] frm_src = hdr_ipv6 ? hdr_src_ip : {{(AW-V4){1'b0}}, hdr_src_ip[V4-1:0]};
  wire [AW-1:0] frm_dst = hdr_ipv6 ? hdr_dst_ip : {{(AW-V4){1'b0}}, hdr_dst_ip[V4-1:0]};

  for (genvar f = 0; f < NF; f++) begin : g_filt
    wire [WW-1:0] c  = cfg_ctrl[f*WW +: WW];
    wire [WW-1:0] pw = cfg_l4[f*WW +: WW];
    wire [WW-1:0] w0 = cfg_l3[f*AW +: WW];
    wire [WW-1:0] w1 = cfg_l3[f*AW + WW +: WW];
    wire [WW-1:0] w2 = cfg_l3[f*AW + 2*WW +: WW];
    wire [WW-1:0] w3 = cfg_l3[f*AW + 3*WW +: WW];

    wire s_en = c[0], s_inv = c[1], d_en = c[2], d_inv = c[3], v6 = c[4];
    wire [6:0] s_msk = c[11:5];
    wire [6:0] d_msk = c[18:12];
    wire sp_en = c[19], sp_inv = c[20], dp_en = c[21], dp_inv = c[22], udp_sel = c[23];

    wire [AW-1:0] a6  = {w0, w1, w2, w3};
    wire [AW-1:0] a_s = v6 ? a6 : {{(AW-V4){1'b0}}, w1};
    wire [AW-1:0] a_d = v6 ? a6 : {{(AW-V4){1'b0}}, w2};
    wire [AW-1:0] k_s = {AW{1'b1}} << s_msk;
    wire [AW-1:0] k_d = {AW{1'b1}} << d_msk;

    wire ver_ok   = (v6 == hdr_ipv6);
    wire proto_ok = (hdr_udp == udp_sel);
    wire cfg_err  = v6 & s_en & d_en;

    wire s_ok  = !s_en  || (ver_ok && ((((a_s ^ frm_src) & k_s) == '0) ^ s_inv));
    wire d_ok  = !d_en  || (ver_ok && ((((a_d ^ frm_dst) & k_d) == '0) ^ d_inv));
    wire sp_ok = !sp_en || (proto_ok && ((hdr_sport == pw[PW-1:0]) ^ sp_inv));
    wire dp_ok = !dp_en || (proto_ok && ((hdr_dport == pw[2*PW-1:PW]) ^ dp_inv));

    assign active[f] = s_en | d_en | sp_en | dp_en;
    assign hit[f]    = active[f] & !cfg_err & s_ok & d_ok & sp_ok & dp_ok & hdr_l4;
  end

  logic [IW-1:0] win;
  always_comb begin
    win = '0;
    for (int i = NF-1; i >= 0; i--)
      if (hit[i]) win = IW'(i);
  end

  logic fwd_n, match_n;
  always_comb begin
    match_n = 1'b0;
    if (!hdr_l4)           fwd_n = !cfg_drop_non_l4;
    else if (active == '0) fwd_n = 1'b1;
    else begin
      match_n = |hit;
      fwd_n   = |hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_forward <= 1'b0;
      dec_match   <= 1'b0;
      dec_idx     <= '0;
      dec_abort   <= 1'b0;
    end else begin
      dec_valid <= hdr_valid;
      if (hdr_valid) begin
        dec_forward <= fwd_n;
        dec_match   <= match_n;
        dec_idx     <= win;
        dec_abort   <= !fwd_n & cfg_abort_mode;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(hdr_valid));
  // R3
  match_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_match) |-> dec_forward);
  // R4
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_abort) |-> (!dec_forward && $past(cfg_abort_mode)));
  // R10
  non_l4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(!hdr_l4)) |-> !dec_match);
  // R3
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && $onehot0(hit) && hit != '0) |=> (dec_idx == $past(win)));

endmodule

// File: tb/l34_filter_match_test.sv
`timescale 1ns/1ps
module l34_filter_match_test;
  localparam int NF = 4;
  logic clk = 0, rst_n = 0;
  logic [NF*32-1:0]  cfg_ctrl = '0, cfg_l4 = '0;
  logic [NF*128-1:0] cfg_l3 = '0;
  logic cfg_drop_non_l4 = 0, cfg_abort_mode = 0;
  logic hdr_valid = 0, hdr_ipv6 = 0, hdr_l4 = 0, hdr_udp = 0;
  logic [127:0] hdr_src_ip = '0, hdr_dst_ip = '0;
  logic [15:0] hdr_sport = '0, hdr_dport = '0;
  logic dec_valid, dec_forward, dec_match, dec_abort;
  logic [1:0] dec_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l34_filter_match uut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic clear_filters();
    cfg_ctrl = '0; cfg_l4 = '0; cfg_l3 = '0;
  endtask

  task automatic set_filt(int f, logic [31:0] c, logic [31:0] p,
                          logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, logic [31:0] w3);
    cfg_ctrl[f*32 +: 32] = c;
    cfg_l4[f*32 +: 32] = p;
    cfg_l3[f*128 +: 128] = {w3, w2, w1, w0};
  endtask

  task automatic send(string tag, logic v6, logic l4, logic udp,
                      logic [127:0] s, logic [127:0] d, logic [15:0] sp, logic [15:0] dp,
                      logic e_fwd, logic e_match, logic [1:0] e_idx, logic e_abort);
    @(negedge clk);
    hdr_valid = 1; hdr_ipv6 = v6; hdr_l4 = l4; hdr_udp = udp;
    hdr_src_ip = s; hdr_dst_ip = d; hdr_sport = sp; hdr_dport = dp;
    @(negedge clk);
    hdr_valid = 0;
    chk({tag, " valid"}, 32'(dec_valid), 1);
    chk({tag, " forward"}, 32'(dec_forward), 32'(e_fwd));
    chk({tag, " match"}, 32'(dec_match), 32'(e_match));
    if (e_match) chk({tag, " idx"}, 32'(dec_idx), 32'(e_idx));
    chk({tag, " abort"}, 32'(dec_abort), 32'(e_abort));
    @(negedge clk);
    chk({tag, " valid drop R1"}, 32'(dec_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(dec_valid), 0);
    chk("R1 reset forward", 32'(dec_forward), 0);
  endtask

  task automatic t_disabled();
    clear_filters();
    send("R5 no active filter", 0, 1, 0, 128'h0A000001, 128'h0A000002, 16'd1, 16'd2, 1, 0, 0, 0);
  endtask

  task automatic t_v4_src();
    clear_filters();
    set_filt(0, 32'h1, 0, 0, 32'hC0A80001, 0, 0);
    cfg_abort_mode = 0;
    send("R2 v4 src exact", 0, 1, 0, 128'hC0A80001, 0, 0, 0, 1, 1, 0, 0);
    send("R4 miss full drop", 0, 1, 0, 128'hC0A80002, 0, 0, 0, 0, 0, 0, 0);
    cfg_abort_mode = 1;
    send("R4 miss partial abort", 0, 1, 0, 128'hC0A80002, 0, 0, 0, 0, 0, 0, 1);
    cfg_abort_mode = 0;
  endtask

  task automatic t_mask();
    clear_filters();
    set_filt(0, 32'h1 | (32'd8 << 5), 0, 0, 32'hC0A80000, 0, 0);
    send("R7 low bits ignored", 0, 1, 0, 128'hC0A800FF, 0, 0, 0, 1, 1, 0, 0);
    send("R7 bit above mask", 0, 1, 0, 128'hC0A801FF, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_inverse();
    clear_filters();
    set_filt(0, 32'h3, 0, 0, 32'hC0A80001, 0, 0);
    send("R6 inverse blocks", 0, 1, 0, 128'hC0A80001, 0, 0, 0, 0, 0, 0, 0);
    send("R6 inverse passes", 0, 1, 0, 128'hC0A80009, 0, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_priority();
    clear_filters();
    set_filt(1, 32'h4, 0, 0, 0, 32'h0A0000FE, 0);
    set_filt(2, 32'h4, 0, 0, 0, 32'h0A0000FE, 0);
    set_filt(3, 32'h4, 0, 0, 0, 32'h0A0000AA, 0);
    send("R3 lowest of two", 0, 1, 0, 0, 128'h0A0000FE, 0, 0, 1, 1, 1, 0);
    send("R3 only filter 3", 0, 1, 0, 0, 128'h0A0000AA, 0, 0, 1, 1, 3, 0);
  endtask

  task automatic t_placement();
    clear_filters();
    set_filt(0, 32'h1, 0, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    send("R8 word0 unused", 0, 1, 0, 128'h11111111, 0, 0, 0, 0, 0, 0, 0);
    send("R8 word1 is src", 0, 1, 0, 128'h22222222, 0, 0, 0, 1, 1, 0, 0);
    set_filt(0, 32'h4, 0, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    send("R8 word2 is dst", 0, 1, 0, 0, 128'h33333333, 0, 0, 1, 1, 0, 0);
  endtask

  task automatic t_ports();
    clear_filters();
    set_filt(0, (32'h1 << 19) | (32'h1 << 21) | (32'h1 << 23), {16'd53, 16'd1000}, 0, 0, 0, 0);
    send("R11 udp ports hit", 0, 1, 1, 0, 0, 16'd1000, 16'd53, 1, 1, 0, 0);
    send("R11 tcp rejected", 0, 1, 0, 0, 0, 16'd1000, 16'd53, 0, 0, 0, 0);
    send("R11 swapped ports", 0, 1, 1, 0, 0, 16'd53, 16'd1000, 0, 0, 0, 0);
    set_filt(0, (32'h1 << 21) | (32'h1 << 22), {16'd53, 16'd0}, 0, 0, 0, 0);
    send("R6 port inverse", 0, 1, 0, 0, 0, 16'd1, 16'd80, 1, 1, 0, 0);
  endtask

  task automatic t_v6();
    clear_filters();
    set_filt(0, 32'h11, 0, 32'h20010DB8, 32'h0, 32'h0, 32'h1);
    send("R9 v6 src hit", 1, 1, 0, 128'h20010DB8_00000000_00000000_00000001, 0, 0, 0, 1, 1, 0, 0);
    send("R9 v6 last byte differs", 1, 1, 0, 128'h20010DB8_00000000_00000000_00000002, 0, 0, 0, 0, 0, 0, 0);
    send("R9 v4 frame vs v6 filter", 0, 1, 0, 128'h00000001, 0, 0, 0, 0, 0, 0, 0);
    set_filt(0, 32'h14, 0, 32'h20010DB8, 32'h0, 32'h0, 32'h1);
    send("R9 v6 dst hit", 1, 1, 0, 0, 128'h20010DB8_00000000_00000000_00000001, 0, 0, 1, 1, 0, 0);
    set_filt(0, 32'h15, 0, 32'h20010DB8, 32'h0, 32'h0, 32'h1);
    send("R9 both enabled", 1, 1, 0, 128'h20010DB8_00000000_00000000_00000001,
         128'h20010DB8_00000000_00000000_00000001, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_non_l4();
    clear_filters();
    set_filt(0, 32'h1, 0, 0, 32'hC0A80001, 0, 0);
    cfg_drop_non_l4 = 0;
    send("R10 bypass", 0, 0, 0, 128'hC0A80001, 0, 0, 0, 1, 0, 0, 0);
    cfg_drop_non_l4 = 1; cfg_abort_mode = 1;
    send("R10 drop abort", 0, 0, 0, 128'hC0A80001, 0, 0, 0, 0, 0, 0, 1);
    cfg_drop_non_l4 = 0; cfg_abort_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_disabled();
    t_v4_src();
    t_mask();
    t_inverse();
    t_priority();
    t_placement();
    t_ports();
    t_v6();
    t_non_l4();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule